// File: doc/BRIEF.md
# Four-Window Overlay Generator with Drop Shadows

This block sits in an on-screen display pipeline just ahead of the colour encoder. For every pixel it takes the current character cell (row and column) and the pixel and line position inside that cell. It then decides whether the pixel lies in the body of one of four rectangular background windows or in the drop shadow that a window casts. It reports a body flag, a shadow flag, a 3-bit colour and an intensity bit. The result is registered, so it appears one clock after the position inputs.

Each window is set up by three bytes written through a simple register port. The bytes give the row range, the column range, the enable, intensity and shadow-enable bits, and the body colour. Further registers hold a 2-bit shadow width code and a 2-bit shadow height code for each window, and a 3-bit shadow colour for each window. When windows overlap, window 0 has the highest priority and window 3 the lowest. A window body always covers any shadow. A single-cycle clear input switches off all four windows at once.

Top module: `osd_winlay`

## Requirements
- R1: After reset every configuration register is zero. The flags, colour and intensity outputs are zero.
- R2: Window n (0..3) has its configuration at addresses 3n, 3n+1 and 3n+2. At 3n, bits 7:4 hold the start row and bits 3:0 hold the end row. At 3n+1, bits 7:3 hold the start column, bit 2 is enable, bit 1 is intensity and bit 0 is shadow enable. At 3n+2, bits 7:3 hold the end column and bits 2:0 hold the colour.
- R3: A pixel whose row and column both lie inside an enabled window's inclusive ranges sets hit_o. It also drives that window's colour on rgb_o and its intensity bit on inten_o (0 meaning low intensity). All outputs change one clock after the position inputs.
- R4: A window whose start row is greater than its end row, or whose start column is greater than its end column, produces neither body nor shadow, even when its enable bit is set.
- R5: Where window bodies overlap, the lowest-numbered window supplies the colour and intensity.
- R6: The right shadow covers the column just past the end column, over the window's rows. It spans pixel offsets below 2·(w+1), where w is the window's 2-bit width code in address 12, bits 2n+1:2n.
- R7: The bottom shadow covers the row just past the end row, for line offsets below 2·(h+1), where h is the window's 2-bit code in address 13, bits 2n+1:2n. It spans the window's columns plus the corner cell limited by the width rule of R6.
- R8: A shadow appears only when the window's shadow-enable bit is set. It sets shadow_o, holds inten_o at 0 and drives the window's shadow colour on rgb_o. Window 2k takes its shadow colour from address 14+k, bits 2:0, and window 2k+1 from address 14+k, bits 6:4.
- R9: A window body outranks every shadow, and hit_o and shadow_o are never both set. Among overlapping shadows, the lowest-numbered window's shadow colour wins.
- R10: A one-cycle pulse on clr_i clears the enable bit of every window. This includes an enable written in the same cycle.
- R11: When no body or shadow covers the pixel, rgb_o and inten_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_i | input | 4 | Current character row |
| col_i | input | 5 | Current character column |
| pix_i | input | 4 | Pixel offset inside the character cell |
| line_i | input | 5 | Line offset inside the character cell |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| clr_i | input | 1 | Clear all window enables |
| hit_o | output | 1 | Pixel lies in a window body |
| shadow_o | output | 1 | Pixel lies in a window shadow only |
| rgb_o | output | 3 | Selected colour |
| inten_o | output | 1 | Selected intensity |

## Verification
The bench probes cells on both sides of every inclusive window edge. A design that used exclusive bounds, or an off-by-one on the column past the end, would lose or gain a border cell. Windows are set up with a start row above the end row, and with a start column above the end column, to catch a design that honours the enable bit alone. Shadows are probed at the last pixel and line inside each width and height code and at the first one outside. The corner cell is probed as well, so a design that decoded the code as 2w, or dropped the corner, shows up. Overlap cases put a body on top of a shadow, and two shadows of different widths on top of each other. A clear is issued in the same cycle as an enable write, which exposes a design that lets the write win.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;

   localparam int ROW_W  = 4;
   localparam int COL_W  = 5;
   localparam int RGB_W  = 3;
   localparam int BYTE_W = 8;
   localparam int CODE_W = 2;

   localparam int EN_BIT  = 2;
   localparam int INT_BIT = 1;
   localparam int SH_BIT  = 0;

   typedef struct packed {
      logic [ROW_W-1:0] rs;
      logic [ROW_W-1:0] re;
      logic [COL_W-1:0] cs;
      logic             en;
      logic             inten;
      logic             shen;
      logic [COL_W-1:0] ce;
      logic [RGB_W-1:0] rgb;
   } win_cfg_t;

endpackage

// File: rtl/osd_win_regs.sv
module osd_win_regs
   import osd_win_pkg::*;
#(
   parameter int NWIN   = 4,
   parameter int ADDR_W = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [BYTE_W-1:0]                 wr_data,
   input  logic                              clr_i,
   output win_cfg_t [NWIN-1:0]               cfg_o,
   output logic [NWIN-1:0][CODE_W-1:0]       wcode_o,
   output logic [NWIN-1:0][CODE_W-1:0]       hcode_o,
   output logic [NWIN-1:0][RGB_W-1:0]        shcol_o
);

   localparam int WSZ_ADDR  = 3 * NWIN;
   localparam int HSZ_ADDR  = WSZ_ADDR + 1;
   localparam int SHC_ADDR  = WSZ_ADDR + 2;
   localparam int SHC_BYTES = NWIN / 2;

   logic [BYTE_W-1:0] wsz_q;
   logic [BYTE_W-1:0] hsz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsz_q <= '0;
         hsz_q <= '0;
      end else begin
         if (wr_en && wr_addr == ADDR_W'(WSZ_ADDR)) wsz_q <= wr_data;
         if (wr_en && wr_addr == ADDR_W'(HSZ_ADDR)) hsz_q <= wr_data;
      end
   end

   for (genvar n = 0; n < NWIN; n++) begin : g_win
      logic [BYTE_W-1:0] b0_q, b1_q, b2_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b0_q <= '0;
            b1_q <= '0;
            b2_q <= '0;
         end else begin
            if (wr_en && wr_addr == ADDR_W'(3*n))   b0_q <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(3*n+1)) b1_q <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(3*n+2)) b2_q <= wr_data;
            // the clear command overrides a same-cycle enable write
            if (clr_i) b1_q[EN_BIT] <= 1'b0;
         end
      end

      always_comb begin
         cfg_o[n].rs    = b0_q[7:4];
         cfg_o[n].re    = b0_q[3:0];
         cfg_o[n].cs    = b1_q[7:3];
         cfg_o[n].en    = b1_q[EN_BIT];
         cfg_o[n].inten = b1_q[INT_BIT];
         cfg_o[n].shen  = b1_q[SH_BIT];
         cfg_o[n].ce    = b2_q[7:3];
         cfg_o[n].rgb   = b2_q[2:0];
      end

      assign wcode_o[n] = wsz_q[2*n +: CODE_W];
      assign hcode_o[n] = hsz_q[2*n +: CODE_W];
   end

   for (genvar k = 0; k < SHC_BYTES; k++) begin : g_shc
      logic [BYTE_W-1:0] shc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shc_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(SHC_ADDR + k))
            shc_q <= wr_data;
      end

      assign shcol_o[2*k]   = shc_q[2:0];
      assign shcol_o[2*k+1] = shc_q[6:4];
   end

endmodule

// File: rtl/osd_win_geom.sv
module osd_win_geom
   import osd_win_pkg::*;
#(
   parameter int PIX_W     = 4,
   parameter int LINE_W    = 5,
   parameter bit SHADOW_ON = 1'b1
) (
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic [LINE_W-1:0] line_i,
   input  win_cfg_t          cfg_i,
   input  logic [CODE_W-1:0] wcode_i,
   input  logic [CODE_W-1:0] hcode_i,
   output logic              valid_o,
   output logic              body_o,
   output logic              shadow_o
);

   logic in_rows, in_cols;

   assign valid_o = cfg_i.en && (cfg_i.rs <= cfg_i.re) && (cfg_i.cs <= cfg_i.ce);
   assign in_rows = (row_i >= cfg_i.rs) && (row_i <= cfg_i.re);
   assign in_cols = (col_i >= cfg_i.cs) && (col_i <= cfg_i.ce);
   assign body_o  = valid_o && in_rows && in_cols;

   if (SHADOW_ON) begin : g_shadow
      logic [PIX_W-1:0]  wsz;
      logic [LINE_W-1:0] hsz;
      logic [COL_W:0]    col_x, ce_p1;
      logic [ROW_W:0]    row_x, re_p1;
      logic              at_right, at_below, px_in, ln_in;
      logic              right_sh, bottom_sh;

      // size = 2 * (code + 1)
      assign wsz   = PIX_W'({wcode_i, 1'b0}) + PIX_W'(2);
      assign hsz   = LINE_W'({hcode_i, 1'b0}) + LINE_W'(2);
      assign col_x = {1'b0, col_i};
      assign ce_p1 = {1'b0, cfg_i.ce} + (COL_W+1)'(1);
      assign row_x = {1'b0, row_i};
      assign re_p1 = {1'b0, cfg_i.re} + (ROW_W+1)'(1);

      assign at_right = (col_x == ce_p1);
      assign at_below = (row_x == re_p1);
      assign px_in    = (pix_i < wsz);
      assign ln_in    = (line_i < hsz);

      assign right_sh  = at_right && px_in && in_rows;
      assign bottom_sh = at_below && ln_in && (in_cols || (at_right && px_in));
      assign shadow_o  = valid_o && cfg_i.shen && (right_sh || bottom_sh);
   end else begin : g_noshadow
      logic unused;
      assign unused   = ^{pix_i, line_i, wcode_i, hcode_i, cfg_i.shen};
      assign shadow_o = 1'b0;
   end

endmodule

// File: rtl/osd_win_sel.sv
module osd_win_sel
   import osd_win_pkg::*;
#(
   parameter int NWIN = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NWIN-1:0]             body_i,
   input  logic [NWIN-1:0]             shadow_i,
   input  win_cfg_t [NWIN-1:0]         cfg_i,
   input  logic [NWIN-1:0][RGB_W-1:0]  shcol_i,
   output logic                        hit_o,
   output logic                        shadow_o,
   output logic [RGB_W-1:0]            rgb_o,
   output logic                        inten_o
);

   logic             n_hit, n_sh, n_int;
   logic [RGB_W-1:0] n_rgb;

   always_comb begin
      n_hit = 1'b0;
      n_sh  = 1'b0;
      n_int = 1'b0;
      n_rgb = '0;
      // scan from lowest priority so the lowest index is applied last
      for (int n = NWIN-1; n >= 0; n--) begin
         if (shadow_i[n]) begin
            n_sh  = 1'b1;
            n_rgb = shcol_i[n];
         end
      end
      for (int n = NWIN-1; n >= 0; n--) begin
         if (body_i[n]) begin
            n_hit = 1'b1;
            n_sh  = 1'b0;
            n_rgb = cfg_i[n].rgb;
            n_int = cfg_i[n].inten;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o    <= 1'b0;
         shadow_o <= 1'b0;
         rgb_o    <= '0;
         inten_o  <= 1'b0;
      end else begin
         hit_o    <= n_hit;
         shadow_o <= n_sh;
         rgb_o    <= n_rgb;
         inten_o  <= n_int;
      end
   end

endmodule

// File: rtl/osd_winlay.sv
module osd_winlay
   import osd_win_pkg::*;
#(
   parameter int NWIN      = 4,
   parameter int PIX_W     = 4,
   parameter int LINE_W    = 5,
   parameter int ADDR_W    = 5,
   parameter bit SHADOW_ON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        row_i,
   input  logic [4:0]        col_i,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              clr_i,
   output logic              hit_o,
   output logic              shadow_o,
   output logic [2:0]        rgb_o,
   output logic              inten_o
);

   localparam int NREG = 3 * NWIN + 2 + NWIN / 2;

   if (NWIN < 2 || (NWIN % 2) != 0 || 2 * NWIN > BYTE_W) begin : g_bad_nwin
      $error("osd_winlay: NWIN must be even and fit one size byte");
   end
   if (NREG > (1 << ADDR_W)) begin : g_bad_addr
      $error("osd_winlay: ADDR_W too small for register map");
   end
   if (PIX_W < 4 || LINE_W < 4) begin : g_bad_off
      $error("osd_winlay: offset inputs must hold a size of 8");
   end

   win_cfg_t [NWIN-1:0]               cfg;
   logic [NWIN-1:0][CODE_W-1:0]       wcode, hcode;
   logic [NWIN-1:0][RGB_W-1:0]        shcol;
   logic [NWIN-1:0]                   body_vec, shadow_vec, valid_vec, en_vec;

   osd_win_regs #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .clr_i   (clr_i),
      .cfg_o   (cfg),
      .wcode_o (wcode),
      .hcode_o (hcode),
      .shcol_o (shcol)
   );

   for (genvar n = 0; n < NWIN; n++) begin : g_geom
      assign en_vec[n] = cfg[n].en;
      osd_win_geom #(.PIX_W(PIX_W), .LINE_W(LINE_W), .SHADOW_ON(SHADOW_ON)) u_geom (
         .row_i    (row_i),
         .col_i    (col_i),
         .pix_i    (pix_i),
         .line_i   (line_i),
         .cfg_i    (cfg[n]),
         .wcode_i  (wcode[n]),
         .hcode_i  (hcode[n]),
         .valid_o  (valid_vec[n]),
         .body_o   (body_vec[n]),
         .shadow_o (shadow_vec[n])
      );
   end

   osd_win_sel #(.NWIN(NWIN)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .body_i   (body_vec),
      .shadow_i (shadow_vec),
      .cfg_i    (cfg),
      .shcol_i  (shcol),
      .hit_o    (hit_o),
      .shadow_o (shadow_o),
      .rgb_o    (rgb_o),
      .inten_o  (inten_o)
   );

endmodule

// File: rtl/osd_winlay_chk.sv
module osd_winlay_chk #(
   parameter int NWIN = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            clr_i,
   input logic            hit_o,
   input logic            shadow_o,
   input logic [2:0]      rgb_o,
   input logic            inten_o,
   input logic [NWIN-1:0] en_vec,
   input logic [NWIN-1:0] valid_vec
);

   // R9
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o && shadow_o));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_o && !shadow_o) |-> (rgb_o == 3'd0 && !inten_o));

   // R8
   shadow_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_o |-> !inten_o);

   // R10
   clear_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (en_vec == '0));

   // R4
   no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_vec == '0) |=> (!hit_o && !shadow_o));

endmodule

bind osd_winlay osd_winlay_chk #(.NWIN(NWIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .hit_o     (hit_o),
   .shadow_o  (shadow_o),
   .rgb_o     (rgb_o),
   .inten_o   (inten_o),
   .en_vec    (en_vec),
   .valid_vec (valid_vec)
);

// File: tb/osd_winlay_bench.sv
`timescale 1ns/1ps
module osd_winlay_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] row_i = '0;
   logic [4:0] col_i = '0;
   logic [3:0] pix_i = '0;
   logic [4:0] line_i = '0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       clr_i = 1'b0;
   logic       hit_o, shadow_o, inten_o;
   logic [2:0] rgb_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   osd_winlay u_osd_winlay (
      .clk(clk), .rst_n(rst_n), .row_i(row_i), .col_i(col_i),
      .pix_i(pix_i), .line_i(line_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clr_i(clr_i), .hit_o(hit_o), .shadow_o(shadow_o),
      .rgb_o(rgb_o), .inten_o(inten_o)
   );

   task automatic chk(string tag, logic eh, logic es, logic [2:0] er, logic ei);
      total++;
      if (hit_o !== eh || shadow_o !== es || rgb_o !== er || inten_o !== ei) begin
         bad++;
         $display("FAIL %s: got hit=%b sh=%b rgb=%0d int=%b, expected hit=%b sh=%b rgb=%0d int=%b",
                  tag, hit_o, shadow_o, rgb_o, inten_o, eh, es, er, ei);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clear_all();
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
   endtask

   task automatic probe(input int r, input int c, input int p, input int l);
      row_i = 4'(r); col_i = 5'(c); pix_i = 4'(p); line_i = 5'(l);
      @(negedge clk);
   endtask

   task automatic t_reset();
      probe(3, 4, 0, 0);
      chk("R1 reset outputs", 0, 0, 3'd0, 0);
      probe(0, 0, 0, 0);
      chk("R11 empty pixel", 0, 0, 3'd0, 0);
   endtask

   task automatic t_body();
      wr(5'd0, 8'h24); wr(5'd1, 8'h1E); wr(5'd2, 8'h35);
      probe(3, 3, 0, 0);  chk("R2 R3 body inside", 1, 0, 3'd5, 1);
      probe(4, 6, 11, 0); chk("R3 inclusive corner", 1, 0, 3'd5, 1);
      probe(5, 3, 0, 0);  chk("R3 below end row", 0, 0, 3'd0, 0);
      probe(1, 4, 0, 0);  chk("R3 above start row", 0, 0, 3'd0, 0);
      probe(2, 7, 0, 0);  chk("R8 no shadow when disabled", 0, 0, 3'd0, 0);
      wr(5'd1, 8'h1C);
      probe(3, 3, 0, 0);  chk("R3 low intensity", 1, 0, 3'd5, 0);
   endtask

   task automatic t_prio();
      wr(5'd3, 8'h38); wr(5'd4, 8'h2E); wr(5'd5, 8'h53);
      probe(3, 5, 0, 0); chk("R5 overlap window0 wins", 1, 0, 3'd5, 0);
      probe(6, 5, 0, 0); chk("R5 window1 alone", 1, 0, 3'd3, 1);
   endtask

   task automatic t_disable();
      wr(5'd6, 8'h97); wr(5'd7, 8'h0C); wr(5'd8, 8'h16);
      probe(8, 1, 0, 0);  chk("R4 row start above end", 0, 0, 3'd0, 0);
      wr(5'd6, 8'h0E); wr(5'd7, 8'h4C); wr(5'd8, 8'h46);
      probe(12, 9, 0, 0); chk("R4 col start above end", 0, 0, 3'd0, 0);
      wr(5'd8, 8'h66);
      probe(12, 10, 0, 0); chk("R4 valid after fix", 1, 0, 3'd6, 0);
      probe(12, 8, 0, 0);  chk("R3 left of start col", 0, 0, 3'd0, 0);
   endtask

   task automatic t_shadow();
      clear_all();
      wr(5'd9, 8'h24); wr(5'd10, 8'h1D); wr(5'd11, 8'h31);
      wr(5'd12, 8'h40); wr(5'd13, 8'h80); wr(5'd15, 8'h70);
      probe(3, 4, 0, 0);  chk("R3 window3 body", 1, 0, 3'd1, 0);
      probe(3, 7, 3, 0);  chk("R6 right shadow last pixel", 0, 1, 3'd7, 0);
      probe(3, 7, 4, 0);  chk("R6 right shadow past width", 0, 0, 3'd0, 0);
      probe(2, 7, 0, 0);  chk("R6 right shadow top row", 0, 1, 3'd7, 0);
      probe(1, 7, 0, 0);  chk("R6 above window", 0, 0, 3'd0, 0);
      probe(5, 3, 0, 5);  chk("R7 bottom shadow last line", 0, 1, 3'd7, 0);
      probe(5, 3, 0, 6);  chk("R7 bottom past height", 0, 0, 3'd0, 0);
      probe(5, 7, 3, 5);  chk("R7 corner inside", 0, 1, 3'd7, 0);
      probe(5, 7, 4, 0);  chk("R7 corner past width", 0, 0, 3'd0, 0);
      probe(5, 2, 0, 0);  chk("R7 left of start col", 0, 0, 3'd0, 0);
      wr(5'd10, 8'h1C);
      probe(3, 7, 0, 0);  chk("R8 shadow enable off", 0, 0, 3'd0, 0);
   endtask

   task automatic t_overlap();
      wr(5'd10, 8'h1D);
      wr(5'd0, 8'h33); wr(5'd1, 8'h3E); wr(5'd2, 8'h3A);
      probe(3, 7, 0, 0); chk("R9 body over shadow", 1, 0, 3'd2, 1);
      wr(5'd3, 8'h24); wr(5'd4, 8'h05); wr(5'd5, 8'h30); wr(5'd14, 8'h40);
      probe(4, 7, 0, 0); chk("R9 shadow priority", 0, 1, 3'd4, 0);
      probe(4, 7, 3, 0); chk("R9 R6 lower shadow wider", 0, 1, 3'd7, 0);
   endtask

   task automatic t_clear();
      probe(3, 7, 0, 0); chk("R10 before clear", 1, 0, 3'd2, 1);
      clr_i = 1'b1; wr_en = 1'b1; wr_addr = 5'd1; wr_data = 8'h3E;
      @(negedge clk);
      clr_i = 1'b0; wr_en = 1'b0;
      probe(3, 7, 0, 0); chk("R10 clear beats write", 0, 0, 3'd0, 0);
      probe(3, 4, 0, 0); chk("R10 all windows off", 0, 0, 3'd0, 0);
      wr(5'd1, 8'h3E);
      probe(3, 7, 0, 0); chk("R10 re-enable", 1, 0, 3'd2, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_body();
      t_prio();
      t_disable();
      t_shadow();
      t_overlap();
      t_clear();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule